// File: doc/BRIEF.md
# Fracturable Six-Input Look-Up Table with Majority-Voted Reads

This block is a behavioural model of a six-input look-up table whose 64 truth-table bits are each stored as a pair: a data bit and its complement. The complement acts as the reference when the bit is read. Two mode inputs set how the table is used. In full mode it computes one function of all six inputs. In dual mode it splits into two five-input functions that share their low five inputs, and the two halves of the table drive two separate outputs.

Each output path reads its selected pair through three redundant read replicas. A majority voter combines them, so a single faulty replica does not change the result. The block also raises flags for three conditions: a replica that disagrees with the vote, a stored pair whose two bits are equal, and an illegal mode setting.

A fault-injection input can force any one replica to a fixed value, so the masking can be checked. Each read takes one clock cycle, and both outputs and all flags are registered.

Top module: `frac_lut6_voted`

## Requirements
- R1: While `rst_n` is low, `out_a`, `out_b`, `err_mode`, `err_pair`, `dis_a` and `dis_b` are all 0. Reset clears every cell to data 0 with reference 1.
- R2: When `cfg_we` is high at a rising clock edge, cell `cfg_addr` stores `cfg_data` as its data bit. Its reference bit becomes the complement of `cfg_data`.
- R3: Full mode is `mode_full`=1 with `mode_dual`=0. In this mode `out_a` gives the data bit of cell `fin` (cell index = `fin` as an unsigned number, so `fin[5]` picks the upper half). `out_b` and `dis_b` stay 0.
- R4: Dual mode is `mode_dual`=1 with `mode_full`=0. In this mode `out_a` gives cell `{0,fin[4:0]}` and `out_b` gives cell `{1,fin[4:0]}`. `fin[5]` has no effect.
- R5: When `mode_full` equals `mode_dual`, the next registered result has `err_mode`=1, and `out_a`, `out_b`, `dis_a`, `dis_b` and `err_pair` are all 0.
- R6: With `flt_en`=1, replica number `flt_sel` is forced to `flt_val`. Replicas 0 to 2 belong to the `out_a` path and replicas 3 to 4 and 5 to the `out_b` path; values 6 and 7 touch nothing. A single forced replica never changes `out_a` or `out_b`.
- R7: `dis_a` (or `dis_b`) is 1 exactly when some replica of an active path differs from that path's voted value. With `flt_en`=0 both flags are 0.
- R8: A write with `cfg_corrupt`=1 stores the reference equal to the data bit. A later read of that cell through an active path sets `err_pair`=1, and the output takes the data bit.
- R9: Every output reflects the inputs sampled at the previous rising edge. A write and a read of the same cell in one cycle return the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one read per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Cell to write |
| cfg_data | input | 1 | Data bit to store |
| cfg_corrupt | input | 1 | Store reference equal to data (test use) |
| mode_full | input | 1 | Select single six-input function |
| mode_dual | input | 1 | Select two five-input functions |
| fin | input | 6 | Function inputs |
| flt_en | input | 1 | Enable replica fault forcing |
| flt_sel | input | 3 | Replica to force (0-2 path A, 3-5 path B) |
| flt_val | input | 1 | Value forced onto the chosen replica |
| out_a | output | 1 | Registered output of the low half / full function |
| out_b | output | 1 | Registered output of the upper half |
| err_mode | output | 1 | Illegal mode combination seen |
| err_pair | output | 1 | A read pair had equal data and reference |
| dis_a | output | 1 | A path-A replica disagreed with the vote |
| dis_b | output | 1 | A path-B replica disagreed with the vote |

## Verification
The properties assume that the table is only made inconsistent through `cfg_corrupt`. They also assume that any disagreement comes from the fault-injection input, so a flag is tied to a fault enabled one cycle earlier on a replica of that path. The stimulus therefore forces at most one replica at a time. Illegal mode settings are mixed in as a small share of the random draws. Configuration writes never overlap reads, which keeps the one-cycle relation between `fin` and the outputs clean for both the properties and the bench model.

// File: rtl/flut_pkg.sv
package flut_pkg;

   typedef enum logic [1:0] {
      MODE_BAD  = 2'd0,
      MODE_FULL = 2'd1,
      MODE_DUAL = 2'd2
   } lut_mode_e;

   function automatic lut_mode_e decode_mode(input logic full, input logic dual);
      if (full && !dual)      return MODE_FULL;
      else if (dual && !full) return MODE_DUAL;
      else                    return MODE_BAD;
   endfunction

endpackage

// File: rtl/flut_store.sv
module flut_store #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned NRD    = 2,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     waddr,
   input  logic                  wdata,
   input  logic                  wcorrupt,
   input  logic [NRD*ADDR_W-1:0] rd_addr,
   output logic [NRD-1:0]        rd_data,
   output logic [NRD-1:0]        rd_ref
);

   logic [DEPTH-1:0] data_q;
   logic [DEPTH-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ref_q  <= '1;
      end else if (we) begin
         data_q[waddr] <= wdata;
         ref_q[waddr]  <= wcorrupt ? wdata : ~wdata;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g] = data_q[rd_addr[g*ADDR_W +: ADDR_W]];
      assign rd_ref[g]  = ref_q[rd_addr[g*ADDR_W +: ADDR_W]];
   end

endmodule

// File: rtl/flut_replica.sv
module flut_replica (
   input  logic d_i,
   input  logic r_i,
   input  logic force_en_i,
   input  logic force_val_i,
   output logic bit_o,
   output logic incon_o
);

   logic sensed;

   // Differential sense: with a valid pair the value follows the inverted
   // reference; with an inconsistent pair the data bit is taken.
   always_comb begin
      incon_o = (d_i == r_i);
      sensed  = incon_o ? d_i : ~r_i;
      bit_o   = force_en_i ? force_val_i : sensed;
   end

endmodule

// File: rtl/flut_vote.sv
module flut_vote #(
   parameter int unsigned REPL = 3
) (
   input  logic [REPL-1:0] rep_i,
   output logic            vote_o,
   output logic            disagree_o
);

   int unsigned ones;

   always_comb begin
      ones       = $countones(rep_i);
      vote_o     = (ones > REPL / 2);
      disagree_o = vote_o ? (ones != REPL) : (ones != 0);
   end

endmodule

// File: rtl/frac_lut6_voted.sv
module frac_lut6_voted
   import flut_pkg::*;
#(
   parameter int unsigned N_IN = 6,
   parameter int unsigned REPL = 3,
   localparam int unsigned NPATH  = 2,
   localparam int unsigned FSEL_W = $clog2(NPATH * REPL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [N_IN-1:0]   cfg_addr,
   input  logic              cfg_data,
   input  logic              cfg_corrupt,
   input  logic              mode_full,
   input  logic              mode_dual,
   input  logic [N_IN-1:0]   fin,
   input  logic              flt_en,
   input  logic [FSEL_W-1:0] flt_sel,
   input  logic              flt_val,
   output logic              out_a,
   output logic              out_b,
   output logic              err_mode,
   output logic              err_pair,
   output logic              dis_a,
   output logic              dis_b
);

   if (N_IN < 2 || REPL < 3 || (REPL % 2) == 0) begin : g_param_bad
      $error("frac_lut6_voted: need N_IN >= 2 and odd REPL >= 3");
   end

   lut_mode_e               mode;
   logic [NPATH*N_IN-1:0]   raddr;
   logic [NPATH-1:0]        rd_data, rd_ref;
   logic [NPATH-1:0]        voted, disagree, incon, live;

   assign mode = decode_mode(mode_full, mode_dual);

   // Path 0: whole table in full mode, low half in dual mode. Path 1: upper half.
   assign raddr[0 +: N_IN]    = (mode == MODE_FULL) ? fin : {1'b0, fin[N_IN-2:0]};
   assign raddr[N_IN +: N_IN] = {1'b1, fin[N_IN-2:0]};

   always_comb begin
      unique case (mode)
         MODE_FULL: live = 2'b01;
         MODE_DUAL: live = 2'b11;
         default:   live = 2'b00;
      endcase
   end

   flut_store #(.ADDR_W(N_IN), .NRD(NPATH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .waddr    (cfg_addr),
      .wdata    (cfg_data),
      .wcorrupt (cfg_corrupt),
      .rd_addr  (raddr),
      .rd_data  (rd_data),
      .rd_ref   (rd_ref)
   );

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      logic [REPL-1:0] rep, rep_incon;
      for (genvar k = 0; k < REPL; k++) begin : g_rep
         flut_replica u_rep (
            .d_i         (rd_data[p]),
            .r_i         (rd_ref[p]),
            .force_en_i  (flt_en && (flt_sel == FSEL_W'(p * REPL + k))),
            .force_val_i (flt_val),
            .bit_o       (rep[k]),
            .incon_o     (rep_incon[k])
         );
      end
      flut_vote #(.REPL(REPL)) u_vote (
         .rep_i      (rep),
         .vote_o     (voted[p]),
         .disagree_o (disagree[p])
      );
      assign incon[p] = |rep_incon;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_a    <= 1'b0;
         out_b    <= 1'b0;
         err_mode <= 1'b0;
         err_pair <= 1'b0;
         dis_a    <= 1'b0;
         dis_b    <= 1'b0;
      end else begin
         out_a    <= voted[0] & live[0];
         out_b    <= voted[1] & live[1];
         dis_a    <= disagree[0] & live[0];
         dis_b    <= disagree[1] & live[1];
         err_pair <= |(incon & live);
         err_mode <= (mode == MODE_BAD);
      end
   end

endmodule

// File: rtl/flut_chk.sv
module flut_chk #(
   parameter int unsigned REPL   = 3,
   parameter int unsigned FSEL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_full,
   input logic              mode_dual,
   input logic              flt_en,
   input logic [FSEL_W-1:0] flt_sel,
   input logic              out_a,
   input logic              out_b,
   input logic              err_mode,
   input logic              err_pair,
   input logic              dis_a,
   input logic              dis_b
);

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!out_a && !out_b && !err_mode && !err_pair && !dis_a && !dis_b); // R1
      end
   end

   AST_BAD_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_full == mode_dual) |=> (err_mode && !out_a && !out_b && !dis_a && !dis_b && !err_pair)); // R5

   AST_GOOD_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_full != mode_dual) |=> !err_mode); // R5

   AST_FULL_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_full && !mode_dual) |=> (!out_b && !dis_b)); // R3

   AST_NO_FAULT_NO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_en |=> (!dis_a && !dis_b)); // R7

   AST_DIS_A_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      dis_a |-> ($past(flt_en) && ($past(flt_sel) < FSEL_W'(REPL)))); // R6

   AST_DIS_B_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      dis_b |-> ($past(flt_en) && ($past(flt_sel) >= FSEL_W'(REPL))
                 && ($past(flt_sel) < FSEL_W'(2 * REPL)))); // R6

endmodule

bind frac_lut6_voted flut_chk #(.REPL(REPL), .FSEL_W(FSEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_full (mode_full),
   .mode_dual (mode_dual),
   .flt_en    (flt_en),
   .flt_sel   (flt_sel),
   .out_a     (out_a),
   .out_b     (out_b),
   .err_mode  (err_mode),
   .err_pair  (err_pair),
   .dis_a     (dis_a),
   .dis_b     (dis_b)
);

// File: tb/frac_lut6_voted_tb.sv
module frac_lut6_voted_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we, cfg_data, cfg_corrupt;
   logic [5:0] cfg_addr;
   logic       mode_full, mode_dual;
   logic [5:0] fin;
   logic       flt_en, flt_val;
   logic [2:0] flt_sel;
   logic       out_a, out_b, err_mode, err_pair, dis_a, dis_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [63:0] m_tbl = '0;
   logic [63:0] m_bad = '0;

   always #10 clk = ~clk;   // 50 MHz

   frac_lut6_voted u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .cfg_corrupt(cfg_corrupt), .mode_full(mode_full),
      .mode_dual(mode_dual), .fin(fin), .flt_en(flt_en), .flt_sel(flt_sel),
      .flt_val(flt_val), .out_a(out_a), .out_b(out_b), .err_mode(err_mode),
      .err_pair(err_pair), .dis_a(dis_a), .dis_b(dis_b)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Called at a falling edge; the write lands at the next rising edge. R2
   task automatic wr(input int a, input logic v, input logic bad);
      cfg_we = 1'b1; cfg_addr = 6'(a); cfg_data = v; cfg_corrupt = bad;
      @(negedge clk);
      cfg_we = 1'b0; cfg_corrupt = 1'b0;
      m_tbl[a] = v;
      m_bad[a] = bad;
   endtask

   // Apply at a falling edge, sample at the next falling edge (one register). R9
   task automatic rd(input logic m6, input logic m5, input logic [5:0] f,
                     input logic fe, input logic [2:0] fs, input logic fv,
                     input string tag);
      logic [5:0] aa, ab;
      logic ea, eb, em, ep, eda, edb;
      mode_full = m6; mode_dual = m5; fin = f;
      flt_en = fe; flt_sel = fs; flt_val = fv;
      @(negedge clk);
      aa = m6 ? f : {1'b0, f[4:0]};
      ab = {1'b1, f[4:0]};
      if (m6 == m5) begin
         {ea, eb, ep, eda, edb} = '0; em = 1'b1;
      end else begin
         em  = 1'b0;
         ea  = m_tbl[aa];
         eb  = m5 ? m_tbl[ab] : 1'b0;
         eda = fe && (fs < 3) && (fv != m_tbl[aa]);
         edb = m5 && fe && (fs >= 3) && (fs < 6) && (fv != m_tbl[ab]);
         ep  = m_bad[aa] | (m5 & m_bad[ab]);
      end
      chk($sformatf("%s out_a", tag), out_a, ea);
      chk($sformatf("%s out_b", tag), out_b, eb);
      chk($sformatf("%s err_mode", tag), err_mode, em);
      chk($sformatf("%s err_pair", tag), err_pair, ep);
      chk($sformatf("%s dis_a", tag), dis_a, eda);
      chk($sformatf("%s dis_b", tag), dis_b, edb);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = 1'b0; cfg_corrupt = 1'b0;
      mode_full = 1'b1; mode_dual = 1'b0; fin = '0;
      flt_en = 1'b0; flt_sel = '0; flt_val = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 out_a", out_a, 1'b0);
      chk("R1 out_b", out_b, 1'b0);
      chk("R1 err_mode", err_mode, 1'b0);
      chk("R1 dis_a", dis_a, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1'b1, 1'b0, 6'd37, 1'b0, 3'd0, 1'b0, "R1 cleared cell");

      for (int a = 0; a < 64; a++) wr(a, 1'($urandom), 1'b0);
      for (int a = 0; a < 64; a++) rd(1'b1, 1'b0, 6'(a), 1'b0, 3'd0, 1'b0, "R2 R3 table");

      wr(9, ~m_tbl[9], 1'b0);
      rd(1'b1, 1'b0, 6'd9, 1'b0, 3'd0, 1'b0, "R2 rewrite");

      rd(1'b0, 1'b1, 6'b000101, 1'b0, 3'd0, 1'b0, "R4 f5 low");
      rd(1'b0, 1'b1, 6'b100101, 1'b0, 3'd0, 1'b0, "R4 f5 high");
      rd(1'b1, 1'b1, 6'd3, 1'b0, 3'd0, 1'b0, "R5 both");
      rd(1'b0, 1'b0, 6'd3, 1'b1, 3'd1, 1'b1, "R5 neither");

      rd(1'b1, 1'b0, 6'd12, 1'b1, 3'd2, ~m_tbl[12], "R6 R7 path a");
      rd(1'b0, 1'b1, 6'd12, 1'b1, 3'd4, ~m_tbl[44], "R6 R7 path b");
      rd(1'b0, 1'b1, 6'd12, 1'b1, 3'd6, ~m_tbl[44], "R6 unused sel");
      rd(1'b1, 1'b0, 6'd50, 1'b1, 3'd5, ~m_tbl[50], "R6 R3 b fault full");

      wr(21, 1'b1, 1'b1);
      wr(53, 1'b0, 1'b1);
      rd(1'b1, 1'b0, 6'd21, 1'b0, 3'd0, 1'b0, "R8 corrupt one");
      rd(1'b1, 1'b0, 6'd53, 1'b0, 3'd0, 1'b0, "R8 corrupt zero");
      rd(1'b0, 1'b1, 6'd21, 1'b0, 3'd0, 1'b0, "R8 dual both bad");
      rd(1'b1, 1'b0, 6'd22, 1'b0, 3'd0, 1'b0, "R8 clean cell");

      // R9: a write and a read of one cell in the same cycle return old data.
      mode_full = 1'b1; mode_dual = 1'b0; fin = 6'd30;
      wr(30, ~m_tbl[30], 1'b0);
      chk("R9 old value", out_a, ~m_tbl[30]);
      rd(1'b1, 1'b0, 6'd30, 1'b0, 3'd0, 1'b0, "R9 new value");

      for (int i = 0; i < 600; i++) begin
         int   r;
         logic m6, m5;
         string tag;
         r = int'($urandom % 10);
         if (r == 0)      begin m6 = 1'b1; m5 = 1'b1; tag = "R5 rnd"; end
         else if (r == 1) begin m6 = 1'b0; m5 = 1'b0; tag = "R5 rnd"; end
         else if (r < 6)  begin m6 = 1'b1; m5 = 1'b0; tag = "R3 R6 R7 rnd"; end
         else             begin m6 = 1'b0; m5 = 1'b1; tag = "R4 R6 R7 rnd"; end
         rd(m6, m5, 6'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), tag);
      end

      finish_up();
   end

endmodule